// File: doc/BRIEF.md
# SDRAM Low-Power and Refresh Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM and owns the clock-enable pin together with the refresh and low-power commands. Refresh requests come from two places: an interval timer inside the block and a level request from outside. It can also take the device into power-down or self-refresh when asked, and bring it back out. A low-power state is entered only while the rest of the controller reports that every bank is closed. Every exit from a low-power state is followed by a row-cycle wait, during which only no-operation commands are driven.

The command outputs are registered. A request that is sampled at one clock edge produces its command in the cycle that follows that edge. After an auto refresh, only no-operation commands go out for the refresh cycle time. After an exit, the wait lasts for the row cycle time. The clock-enable output never changes level sooner than a minimum run of cycles. When a refresh falls due and a power-down request is also present, the refresh wins. When a refresh falls due while the device is in power-down, the block wakes the device by itself and then issues the refresh.

Command encoding on {cs_n, ras_n, cas_n, we_n}: no-operation is 0111 and refresh is 0001. The same refresh pattern driven with clock enable low is the self-refresh entry.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: While reset is applied, and afterwards while no request is present, cke is 1 and the command is no-operation (0111).
- R2: When banks_idle and ar_req are both high at an edge in the idle state, the next cycle shows refresh (0001) with cke 1. The following RFC_CYC-1 cycles show no-operation with cke 1.
- R3: With no other activity, the interval timer causes a refresh every REFI_CYC cycles. The first one appears REFI_CYC+1 cycles after the cycle in which reset is released.
- R4: A refresh that is due stays pending while banks_idle is low. It is issued in the cycle after banks_idle is sampled high.
- R5: While banks_idle is low, cke does not fall, even if power-down or self-refresh is requested.
- R6: Self-refresh entry drives cke 0 together with the refresh encoding (0001) in the same cycle. cke then stays 0 until an exit.
- R7: Power-down entry drives cke 0 together with no-operation (0111). cke stays 0 while the device remains in power-down.
- R8: If a refresh is due and pd_req or sr_req is also high, the refresh is issued first.
- R9: An exit from either low-power state raises cke together with no-operation. The following RC_CYC-1 cycles show only no-operation with cke 1.
- R10: cke holds each level for at least CKE_MIN cycles. An exit request that arrives earlier takes effect only once this run is met.
- R11: In power-down, a refresh falling due causes an automatic exit. The refresh follows as soon as the row-cycle wait ends.
- R12: The interval timer is stopped and cleared during self-refresh. The first timer refresh after an exit appears REFI_CYC+1 cycles after the cycle in which cke rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| banks_idle | input | 1 | High when every bank is precharged |
| ar_req | input | 1 | Level request for an auto refresh |
| sr_req | input | 1 | Level request to enter self-refresh |
| pd_req | input | 1 | Level request to enter power-down |
| exit_req | input | 1 | Level request to leave a low-power state |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that banks_idle reflects the bank state truthfully, and that nothing other than this block drives commands while it is active. They also assume the requests are levels, held until the block acts on them. The stimulus keeps banks_idle high whenever it expects a low-power entry or a refresh. It drops banks_idle only to show that entry and refresh are held off. It raises exit_req only while the device is in a low-power state and lowers it as soon as the exit is seen. The scenarios are timed against the timer phase, which the bench recovers from observed refresh commands, so that no timer refresh falls inside a window where a different result is expected.

// File: rtl/lp_pkg.sv
`timescale 1ns/1ps
package lp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PD   = 2'd2,
    ST_SR   = 2'd3
  } lp_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;

  // value loaded into a wait counter so that the next command lands n cycles
  // after the cycle that started the wait
  function automatic int unsigned hold_last(input int unsigned n);
    return n - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lp_refresh_timer.sv
`timescale 1ns/1ps
module lp_refresh_timer #(
  parameter int unsigned PERIOD = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic clear_i,
  output logic pend_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)         pend_o <= 1'b1;
      else if (clear_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lp_cke_guard.sv
`timescale 1ns/1ps
module lp_cke_guard #(
  parameter int unsigned MIN_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_cur_i,
  input  logic cke_next_i,
  output logic ok_o
);
  localparam int unsigned RW = $clog2(MIN_RUN + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (cke_next_i != cke_cur_i) begin
      run_q <= RW'(1);
    end else if (run_q != RW'(MIN_RUN)) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign ok_o = (run_q >= RW'(MIN_RUN));
endmodule

// File: rtl/lp_wait_counter.sv
`timescale 1ns/1ps
module lp_wait_counter #(
  parameter int unsigned WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [WW-1:0] load_val_i,
  output logic          done_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == WW'(1));
endmodule

// File: rtl/lp_fsm.sv
`timescale 1ns/1ps
module lp_fsm
  import lp_pkg::*;
#(
  parameter int unsigned RFC_CYC = 15,
  parameter int unsigned RC_CYC  = 10,
  parameter int unsigned WW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          banks_idle_i,
  input  logic          need_ref_i,
  input  logic          sr_req_i,
  input  logic          pd_req_i,
  input  logic          exit_req_i,
  input  logic          cke_ok_i,
  input  logic          wait_done_i,
  output logic          cke_o,
  output logic [3:0]    cmd_o,
  output logic          cke_next_o,
  output logic          load_o,
  output logic [WW-1:0] load_val_o,
  output logic          ref_issue_o,
  output logic          in_sr_o
);
  lp_state_e  st_q, st_d;
  logic [3:0] cmd_d;
  logic       cke_d;

  always_comb begin
    st_d        = st_q;
    cke_d       = 1'b1;
    cmd_d       = CMD_NOP;
    load_o      = 1'b0;
    load_val_o  = '0;
    ref_issue_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (banks_idle_i && need_ref_i) begin
          cmd_d       = CMD_REF;
          ref_issue_o = 1'b1;
          load_o      = 1'b1;
          load_val_o  = WW'(hold_last(RFC_CYC));
          st_d        = ST_WAIT;
        end else if (banks_idle_i && sr_req_i && cke_ok_i) begin
          cke_d = 1'b0;
          cmd_d = CMD_REF;
          st_d  = ST_SR;
        end else if (banks_idle_i && pd_req_i && cke_ok_i) begin
          cke_d = 1'b0;
          st_d  = ST_PD;
        end
      end
      ST_WAIT: begin
        if (wait_done_i) st_d = ST_IDLE;
      end
      ST_PD: begin
        cke_d = 1'b0;
        if ((exit_req_i || need_ref_i) && cke_ok_i) begin
          cke_d      = 1'b1;
          load_o     = 1'b1;
          load_val_o = WW'(hold_last(RC_CYC));
          st_d       = ST_WAIT;
        end
      end
      ST_SR: begin
        cke_d = 1'b0;
        if (exit_req_i && cke_ok_i) begin
          cke_d      = 1'b1;
          load_o     = 1'b1;
          load_val_o = WW'(hold_last(RC_CYC));
          st_d       = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cke_o <= 1'b1;
      cmd_o <= CMD_NOP;
    end else begin
      st_q  <= st_d;
      cke_o <= cke_d;
      cmd_o <= cmd_d;
    end
  end

  assign cke_next_o = cke_d;
  assign in_sr_o    = (st_q == ST_SR);
endmodule

// File: rtl/sdram_lp_ctrl.sv
`timescale 1ns/1ps
module sdram_lp_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned REFI_CYC = 1040,
  parameter int unsigned RFC_CYC  = 15,
  parameter int unsigned RC_CYC   = 10,
  parameter int unsigned CKE_MIN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ar_req,
  input  logic sr_req,
  input  logic pd_req,
  input  logic exit_req,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned WAIT_MAX = max2(RFC_CYC, RC_CYC);
  localparam int unsigned WW       = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1;

  // named internal events, also seen by the bound checker
  logic          ref_pend;
  logic          ref_need;
  logic          ref_issue;
  logic          sr_hold;
  logic          cke_ok;
  logic          cke_next;
  logic          wait_done;
  logic          wait_load;
  logic [WW-1:0] wait_val;
  logic [3:0]    cmd;

  assign ref_need = ref_pend | ar_req;

  lp_refresh_timer #(.PERIOD(REFI_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (sr_hold),
    .clear_i (ref_issue),
    .pend_o  (ref_pend)
  );

  lp_cke_guard #(.MIN_RUN(CKE_MIN)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_cur_i  (cke),
    .cke_next_i (cke_next),
    .ok_o       (cke_ok)
  );

  lp_wait_counter #(.WW(WW)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wait_load),
    .load_val_i (wait_val),
    .done_o     (wait_done)
  );

  lp_fsm #(.RFC_CYC(RFC_CYC), .RC_CYC(RC_CYC), .WW(WW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .banks_idle_i (banks_idle),
    .need_ref_i   (ref_need),
    .sr_req_i     (sr_req),
    .pd_req_i     (pd_req),
    .exit_req_i   (exit_req),
    .cke_ok_i     (cke_ok),
    .wait_done_i  (wait_done),
    .cke_o        (cke),
    .cmd_o        (cmd),
    .cke_next_o   (cke_next),
    .load_o       (wait_load),
    .load_val_o   (wait_val),
    .ref_issue_o  (ref_issue),
    .in_sr_o      (sr_hold)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/lp_ctrl_checker.sv
`timescale 1ns/1ps
module lp_ctrl_checker #(
  parameter int unsigned RFC_CYC = 15,
  parameter int unsigned RC_CYC  = 10,
  parameter int unsigned CKE_MIN = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       banks_idle,
  input logic       cke,
  input logic [3:0] cmd,
  input logic       ref_pend,
  input logic       ref_issue,
  input logic       sr_hold
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;

  logic        cke_prev;
  int unsigned run;
  int unsigned q_rfc;
  int unsigned q_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
      run      <= 0;
      q_rfc    <= 0;
      q_rc     <= 0;
    end else begin
      cke_prev <= cke;
      if (cke != cke_prev)   run <= 1;
      else if (run < CKE_MIN) run <= run + 1;
      if (cke && cmd == REF) q_rfc <= RFC_CYC - 1;
      else if (q_rfc != 0)   q_rfc <= q_rfc - 1;
      if (cke && !cke_prev)  q_rc <= RC_CYC - 1;
      else if (q_rc != 0)    q_rc <= q_rc - 1;
    end
  end

  a_r2_rfc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rfc != 0) |-> (cke && cmd == NOP));

  a_r9_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rc != 0) |-> (cke && cmd == NOP));

  a_r9_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == NOP));

  a_r10_cke_width: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != cke_prev) |-> (run >= CKE_MIN));

  a_r5_entry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(banks_idle));

  // R6 and R7: entry carries either the self-refresh or the no-operation code
  a_r6_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == REF || cmd == NOP));

  a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_issue && !sr_hold) |=> ref_pend);
endmodule

bind sdram_lp_ctrl lp_ctrl_checker #(
  .RFC_CYC (RFC_CYC),
  .RC_CYC  (RC_CYC),
  .CKE_MIN (CKE_MIN)
) u_lp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .banks_idle (banks_idle),
  .cke        (cke),
  .cmd        (cmd),
  .ref_pend   (ref_pend),
  .ref_issue  (ref_issue),
  .sr_hold    (sr_hold)
);

// File: tb/tb_sdram_lp_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_lp_ctrl;
  localparam int REFI = 120;
  localparam int RFC  = 15;
  localparam int RC   = 10;
  localparam int CKM  = 2;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1;
  logic ar_req = 1'b0, sr_req = 1'b0, pd_req = 1'b0, exit_req = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [3:0] cmd_w;

  assign cmd_w = {cs_n, ras_n, cas_n, we_n};

  sdram_lp_ctrl #(.REFI_CYC(REFI), .RFC_CYC(RFC), .RC_CYC(RC), .CKE_MIN(CKM)) dut (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ar_req(ar_req),
    .sr_req(sr_req), .pd_req(pd_req), .exit_req(exit_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;

  // scoreboard of expected outputs, indexed by cycle
  int         q_at[$];
  logic [4:0] q_val[$];
  string      q_tag[$];

  task automatic push1(input int at, input logic k, input logic [3:0] c, input string tag);
    q_at.push_back(at);
    q_val.push_back({k, c});
    q_tag.push_back(tag);
  endtask

  task automatic push_range(input int a, input int b, input logic k, input string tag);
    for (int i = a; i <= b; i++) push1(i, k, NOP, tag);
  endtask

  task automatic compare(input string tag, input logic [4:0] exp_v, input logic [4:0] got_v);
    n_vec++;
    if (got_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d: cke=%b cmd=%b, expected cke=%b cmd=%b",
               tag, cyc, got_v[4], got_v[3:0], exp_v[4], exp_v[3:0]);
    end
  endtask

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    for (int i = q_at.size() - 1; i >= 0; i--) begin
      if (q_at[i] <= cyc) begin
        if (q_at[i] == cyc) compare(q_tag[i], q_val[i], {cke, cmd_w});
        else begin
          n_vec++; n_bad++;
          $display("FAIL %s stale entry for cycle %0d: actual n/a, expected cke=%b cmd=%b",
                   q_tag[i], q_at[i], q_val[i][4], q_val[i][3:0]);
        end
        q_at.delete(i); q_val.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic sync_ref(output int c);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!(cke === 1'b1 && cmd_w === REF) && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 400) begin
      n_vec++; n_bad++;
      $display("FAIL R3 no refresh seen: actual none, expected a refresh");
    end
    c = cyc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int b;
    int t;
    int p;
    repeat (4) @(negedge clk);
    compare("R1", {1'b1, NOP}, {cke, cmd_w});   // R1 during reset
    rst_n = 1'b1;
    b = cyc;
    push_range(b + 1, b + REFI, 1'b1, "R1");
    push1(b + REFI + 1, 1'b1, REF, "R3");
    at_cyc(b + REFI + 1);

    // R2 external refresh, R3 timer period unaffected
    b = cyc;
    at_cyc(b + 20); ar_req = 1'b1;
    push1(b + 21, 1'b1, REF, "R2");
    push_range(b + 22, b + 20 + RFC, 1'b1, "R2");
    at_cyc(b + 21); ar_req = 1'b0;
    push_range(b + 21 + RFC, b + REFI - 1, 1'b1, "R3");
    push1(b + REFI, 1'b1, REF, "R3");
    at_cyc(b + REFI);

    // R6 self-refresh entry, R9 exit, R12 timer restart
    b = cyc;
    at_cyc(b + 15); sr_req = 1'b1;
    push1(b + 16, 1'b0, REF, "R6");
    at_cyc(b + 16); sr_req = 1'b0;
    push_range(b + 17, b + 46, 1'b0, "R6");
    at_cyc(b + 46); exit_req = 1'b1;
    push1(b + 47, 1'b1, NOP, "R9");
    at_cyc(b + 47); exit_req = 1'b0;
    push_range(b + 48, b + 46 + RC, 1'b1, "R9");
    push_range(b + 47 + RC, b + 47 + REFI, 1'b1, "R12");
    push1(b + 48 + REFI, 1'b1, REF, "R12");
    at_cyc(b + 48 + REFI);

    // R7 power-down entry, R11 automatic exit for refresh, R8 priority
    b = cyc;
    at_cyc(b + 15); pd_req = 1'b1;
    push1(b + 16, 1'b0, NOP, "R7");
    push_range(b + 17, b + REFI - 1, 1'b0, "R7");
    push1(b + REFI, 1'b1, NOP, "R11");
    push_range(b + REFI + 1, b + REFI + RC - 1, 1'b1, "R9");
    push1(b + REFI + RC, 1'b1, REF, "R11");
    at_cyc(b + REFI + RC); pd_req = 1'b0;
    push_range(b + REFI + RC + 1, b + REFI + RC + RFC - 1, 1'b1, "R2");
    at_cyc(b + REFI + RC + RFC - 1);

    // R5 banks busy, R4 held refresh, R8 priority, R10 minimum cke run
    sync_ref(b);
    at_cyc(b + 1); banks_idle = 1'b0;
    at_cyc(b + 15); pd_req = 1'b1; sr_req = 1'b1;
    push_range(b + 16, b + REFI - 1, 1'b1, "R5");
    push_range(b + REFI, b + REFI + 10, 1'b1, "R4");
    at_cyc(b + REFI + 10); banks_idle = 1'b1; sr_req = 1'b0;
    t = b + REFI + 11;
    p = t + RFC;
    push1(t, 1'b1, REF, "R8");
    push_range(t + 1, t + RFC - 1, 1'b1, "R2");
    push1(p, 1'b0, NOP, "R7");
    at_cyc(p); pd_req = 1'b0; exit_req = 1'b1;
    push1(p + 1, 1'b0, NOP, "R10");
    push1(p + 2, 1'b1, NOP, "R10");
    at_cyc(p + 2); exit_req = 1'b0;
    push_range(p + 3, p + RC + 1, 1'b1, "R9");
    at_cyc(p + RC + 3);

    if (q_at.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R1 leftover expectations: actual %0d, expected 0", q_at.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule